// File: doc/BRIEF.md
# Multi-Port Request Dealer

The dealer takes one stream of memory requests (a load or store flag, an address and write data) and hands each request to one of several per-CPU request ports. Each accepted request is held in a single register slot. It is offered to exactly one target port until that port takes it. Responses that come back from the ports are merged into one registered output stream, and each response is tagged with the index of the port that produced it.

Two runtime modes exist. In streaming mode a new request enters the slot in the same cycle as the previous one leaves, so a ready port receives one request per clock. In serial mode the dealer delivers one request and then refuses input until that port has answered, so at most one request is in flight at any time. The target normally rotates over the ports. A pinning option sends every request to one chosen port instead, which lets each CPU port be brought up on its own before all of them run together. Mode and pinning settings are captured only while nothing is held or awaited.

Top module: `req_dealer`

## Requirements
- R1: Every request accepted on the input is presented on exactly one port, with its load/store flag, address and write data unchanged; at most one bit of `prt_valid` is high in any cycle.
- R2: While pinning is off, successive accepted requests target port 0, 1, ..., N_PORTS-1 and then wrap to 0, in order of acceptance.
- R3: While pinning is on, every request targets port `cfg_port`, and the rotation position is frozen: the first request after pinning ends goes to the port that would have been next before pinning began.
- R4: In streaming mode with the target ports ready, the input is accepted in the same cycle that the slot hands its request to a port, so deliveries occur on consecutive clock cycles.
- R5: In serial mode, after a request is delivered no input is accepted until the response from that port has been taken; at most one request is ever outstanding (delivered and not yet answered).
- R6: A request offered to a port that is not ready stays offered to that same port with unchanged contents, and later requests wait behind it; they are not sent to other ports.
- R7: Port responses are taken one per cycle, with the lowest-numbered valid port first (`prt_rsp_ready` is one-hot or zero). A response taken at a clock edge appears on `rsp_valid`/`rsp_port`/`rsp_data` directly after that edge.
- R8: Changes on `cfg_serial`, `cfg_single` and `cfg_port` take effect only in a cycle where the slot is empty, no serial response is awaited and no request is being accepted; until then the previous settings govern.
- R9: After reset no port request and no response are valid, the input is ready, streaming mode is active, pinning is off and the rotation starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial | input | 1 | 1 selects serial mode, 0 selects streaming |
| cfg_single | input | 1 | 1 pins all requests to `cfg_port` |
| cfg_port | input | IDX_W | Port index used while pinned |
| req_valid | input | 1 | Input request valid |
| req_ready | output | 1 | Input request accepted when high together with `req_valid` |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data |
| prt_valid | output | N_PORTS | Per-port request valid, at most one high |
| prt_ready | input | N_PORTS | Per-port request ready |
| prt_we | output | N_PORTS | Per-port load/store flag |
| prt_addr | output | N_PORTS*ADDR_W | Per-port address, port p in bits p*ADDR_W upward |
| prt_wdata | output | N_PORTS*DATA_W | Per-port store data, port p in bits p*DATA_W upward |
| prt_rsp_valid | input | N_PORTS | Per-port response valid |
| prt_rsp_ready | output | N_PORTS | Per-port response taken this cycle |
| prt_rsp_data | input | N_PORTS*DATA_W | Per-port response data |
| rsp_valid | output | 1 | Merged response valid |
| rsp_port | output | IDX_W | Index of the port that produced the response |
| rsp_data | output | DATA_W | Merged response data |

## Verification
The assertions assume that a port raises `prt_rsp_valid` only for a request it has received and keeps it high with stable data until `prt_rsp_ready` takes it, that in serial mode only the port holding the single outstanding request answers, and that `cfg_port` stays below N_PORTS. The bench port models answer only requests they logged, queue their answers and can hold them back on command, never release a response until it is taken, and the stimulus changes configuration only across idle gaps or while a request is deliberately parked to probe the deferral.

// File: rtl/dealer_pkg.sv
package dealer_pkg;

  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_SERIAL = 1'b1
  } deal_mode_e;

endpackage

// File: rtl/dealer_target.sv
// Rotation pointer and target choice for the next request entering the slot.
module dealer_target #(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             pinned,
  input  logic [IDX_W-1:0] pin_idx,
  output logic [IDX_W-1:0] tgt
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PORTS - 1);

  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (take && !pinned) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  assign tgt = pinned ? pin_idx : ptr;

endmodule

// File: rtl/dealer_ctrl.sv
// Captures configuration while idle and tracks the serial-mode wait.
module dealer_ctrl
  import dealer_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_serial,
  input  logic               cfg_single,
  input  logic [IDX_W-1:0]   cfg_port,
  input  logic               slot_v,
  input  logic               load,
  input  logic               fire,
  input  logic [IDX_W-1:0]   slot_tgt,
  input  logic [N_PORTS-1:0] grant,
  output deal_mode_e         mode_q,
  output logic               single_q,
  output logic [IDX_W-1:0]   idx_q,
  output logic               wait_q
);

  logic [IDX_W-1:0] wait_idx;
  logic             quiet;

  assign quiet = !slot_v && !wait_q && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_STREAM;
      single_q <= 1'b0;
      idx_q    <= '0;
    end else if (quiet) begin
      mode_q   <= cfg_serial ? MODE_SERIAL : MODE_STREAM;
      single_q <= cfg_single;
      idx_q    <= cfg_port;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q   <= 1'b0;
      wait_idx <= '0;
    end else if (fire && (mode_q == MODE_SERIAL)) begin
      wait_q   <= 1'b1;
      wait_idx <= slot_tgt;
    end else if (wait_q && grant[wait_idx]) begin
      wait_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/dealer_slot.sv
// Single request register with a one-hot, registered per-port valid.
module dealer_slot #(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               ld_we,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0]  ld_wdata,
  input  logic [IDX_W-1:0]   ld_tgt,
  input  logic [N_PORTS-1:0] prt_ready,
  output logic               slot_v,
  output logic [IDX_W-1:0]   slot_tgt,
  output logic               fire,
  output logic [N_PORTS-1:0] vmask,
  output logic               s_we,
  output logic [ADDR_W-1:0]  s_addr,
  output logic [DATA_W-1:0]  s_wdata
);

  assign fire = slot_v && prt_ready[slot_tgt];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v <= 1'b0;
      vmask  <= '0;
    end else if (load) begin
      slot_v <= 1'b1;
      vmask  <= N_PORTS'(1) << ld_tgt;
    end else if (fire) begin
      slot_v <= 1'b0;
      vmask  <= '0;
    end
  end

  // Payload needs no reset; vmask qualifies it.
  always_ff @(posedge clk) begin
    if (load) begin
      slot_tgt <= ld_tgt;
      s_we     <= ld_we;
      s_addr   <= ld_addr;
      s_wdata  <= ld_wdata;
    end
  end

endmodule

// File: rtl/dealer_rsp_merge.sv
// Fixed-priority merge of port responses onto one registered stream.
module dealer_rsp_merge #(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS-1:0]        rp_valid,
  input  logic [N_PORTS*DATA_W-1:0] rp_data,
  output logic [N_PORTS-1:0]        rp_ready,
  output logic                      out_valid,
  output logic [IDX_W-1:0]          out_port,
  output logic [DATA_W-1:0]         out_data
);

  logic             found;
  logic [IDX_W-1:0] sel;

  always_comb begin
    found    = 1'b0;
    sel      = '0;
    rp_ready = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (rp_valid[i] && !found) begin
        found       = 1'b1;
        sel         = IDX_W'(i);
        rp_ready[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= found;
    end
  end

  always_ff @(posedge clk) begin
    if (found) begin
      out_port <= sel;
      out_data <= rp_data[int'(sel)*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/req_dealer.sv
module req_dealer
  import dealer_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_serial,
  input  logic                      cfg_single,
  input  logic [IDX_W-1:0]          cfg_port,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic [N_PORTS-1:0]        prt_valid,
  input  logic [N_PORTS-1:0]        prt_ready,
  output logic [N_PORTS-1:0]        prt_we,
  output logic [N_PORTS*ADDR_W-1:0] prt_addr,
  output logic [N_PORTS*DATA_W-1:0] prt_wdata,
  input  logic [N_PORTS-1:0]        prt_rsp_valid,
  output logic [N_PORTS-1:0]        prt_rsp_ready,
  input  logic [N_PORTS*DATA_W-1:0] prt_rsp_data,
  output logic                      rsp_valid,
  output logic [IDX_W-1:0]          rsp_port,
  output logic [DATA_W-1:0]         rsp_data
);

  deal_mode_e       mode_q;
  logic             single_q;
  logic [IDX_W-1:0] idx_q;
  logic             wait_q;
  logic             slot_v;
  logic             fire;
  logic             load;
  logic [IDX_W-1:0] next_tgt;
  logic [IDX_W-1:0] slot_tgt;
  logic             s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;

  // Serial: only from a fully idle state. Streaming: refill as the slot drains.
  assign req_ready = (mode_q == MODE_SERIAL) ? (!slot_v && !wait_q)
                                             : (!slot_v || fire);
  assign load = req_valid && req_ready;

  dealer_target #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_target (
    .clk     (clk),
    .rst     (rst),
    .take    (load),
    .pinned  (single_q),
    .pin_idx (idx_q),
    .tgt     (next_tgt)
  );

  dealer_ctrl #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg_serial (cfg_serial),
    .cfg_single (cfg_single),
    .cfg_port   (cfg_port),
    .slot_v     (slot_v),
    .load       (load),
    .fire       (fire),
    .slot_tgt   (slot_tgt),
    .grant      (prt_rsp_ready),
    .mode_q     (mode_q),
    .single_q   (single_q),
    .idx_q      (idx_q),
    .wait_q     (wait_q)
  );

  dealer_slot #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ld_we     (req_we),
    .ld_addr   (req_addr),
    .ld_wdata  (req_wdata),
    .ld_tgt    (next_tgt),
    .prt_ready (prt_ready),
    .slot_v    (slot_v),
    .slot_tgt  (slot_tgt),
    .fire      (fire),
    .vmask     (prt_valid),
    .s_we      (s_we),
    .s_addr    (s_addr),
    .s_wdata   (s_wdata)
  );

  // Payload is broadcast; only the valid bit selects the port.
  for (genvar p = 0; p < N_PORTS; p++) begin : g_fan
    assign prt_we[p]                        = s_we;
    assign prt_addr[p*ADDR_W +: ADDR_W]     = s_addr;
    assign prt_wdata[p*DATA_W +: DATA_W]    = s_wdata;
  end

  dealer_rsp_merge #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .rp_valid  (prt_rsp_valid),
    .rp_data   (prt_rsp_data),
    .rp_ready  (prt_rsp_ready),
    .out_valid (rsp_valid),
    .out_port  (rsp_port),
    .out_data  (rsp_data)
  );

endmodule

// File: rtl/req_dealer_chk.sv
module req_dealer_chk #(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_ready,
  input logic [N_PORTS-1:0]        prt_valid,
  input logic [N_PORTS-1:0]        prt_ready,
  input logic [N_PORTS-1:0]        prt_we,
  input logic [N_PORTS*ADDR_W-1:0] prt_addr,
  input logic [N_PORTS*DATA_W-1:0] prt_wdata,
  input logic [N_PORTS-1:0]        prt_rsp_valid,
  input logic [N_PORTS-1:0]        prt_rsp_ready,
  input logic                      rsp_valid,
  input logic                      mode_q,
  input logic                      single_q,
  input logic [IDX_W-1:0]          idx_q,
  input logic                      wait_q,
  input logic                      slot_v
);

  // R1
  port_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prt_valid));

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (|(prt_valid & ~prt_ready)) |=>
      ($stable(prt_valid) && $stable(prt_addr) && $stable(prt_wdata) && $stable(prt_we)));

  // R5
  serial_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && wait_q) |-> !req_ready);

  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    (single_q && (|prt_valid)) |-> (prt_valid == (N_PORTS'(1) << idx_q)));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prt_rsp_ready));

  // R7
  merge_out_chk: assert property (@(posedge clk) disable iff (rst)
    (|prt_rsp_valid) |=> rsp_valid);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_v || wait_q) |=> ($stable(mode_q) && $stable(single_q) && $stable(idx_q)));

endmodule

bind req_dealer req_dealer_chk #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_ready     (req_ready),
  .prt_valid     (prt_valid),
  .prt_ready     (prt_ready),
  .prt_we        (prt_we),
  .prt_addr      (prt_addr),
  .prt_wdata     (prt_wdata),
  .prt_rsp_valid (prt_rsp_valid),
  .prt_rsp_ready (prt_rsp_ready),
  .rsp_valid     (rsp_valid),
  .mode_q        (mode_q),
  .single_q      (single_q),
  .idx_q         (idx_q),
  .wait_q        (wait_q),
  .slot_v        (slot_v)
);

// File: tb/req_dealer_tb.sv
`timescale 1ns/1ps
module req_dealer_tb;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic cfg_serial, cfg_single;
  logic [IW-1:0] cfg_port;
  logic req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [N-1:0] prt_valid, prt_ready, prt_we, prt_rsp_valid, prt_rsp_ready;
  logic [N*AW-1:0] prt_addr;
  logic [N*DW-1:0] prt_wdata, prt_rsp_data;
  logic rsp_valid;
  logic [IW-1:0] rsp_port;
  logic [DW-1:0] rsp_data;

  req_dealer #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_serial(cfg_serial), .cfg_single(cfg_single),
    .cfg_port(cfg_port), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .prt_valid(prt_valid), .prt_ready(prt_ready), .prt_we(prt_we),
    .prt_addr(prt_addr), .prt_wdata(prt_wdata), .prt_rsp_valid(prt_rsp_valid),
    .prt_rsp_ready(prt_rsp_ready), .prt_rsp_data(prt_rsp_data),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_ptr = 0;
  bit done = 0;

  // Port models: queue answers (address + 0x1000_0000), optional hold.
  bit [N-1:0] rdy_en;
  bit rsp_hold;
  logic [DW-1:0] q [N][16];
  logic [3:0] wp [N];
  logic [3:0] rp [N];
  assign prt_ready = rdy_en;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      prt_rsp_valid[p] = (wp[p] != rp[p]) && !rsp_hold;
      prt_rsp_data[p*DW +: DW] = q[p][rp[p]];
    end
  end

  logic [IW-1:0] dlog_port [64];
  logic [AW-1:0] dlog_addr [64];
  logic [DW-1:0] dlog_data [64];
  logic          dlog_we   [64];
  int            dlog_cyc  [64];
  int dcount = 0;
  logic [IW-1:0] rlog_port [64];
  logic [DW-1:0] rlog_data [64];
  int rcount = 0;
  int ostd = 0;
  int ostd_max = 0;

  always @(posedge clk) begin
    int f, g;
    cyc <= cyc + 1;
    if (rst) begin
      for (int p = 0; p < N; p++) begin
        wp[p] <= '0;
        rp[p] <= '0;
      end
      ostd <= 0;
    end else begin
      f = 0;
      g = 0;
      for (int p = 0; p < N; p++) begin
        if (prt_valid[p] && prt_ready[p]) begin
          q[p][wp[p]] <= prt_addr[p*AW +: AW] + 32'h1000_0000;
          wp[p] <= wp[p] + 1'b1;
          if (dcount < 64) begin
            dlog_port[dcount] <= IW'(p);
            dlog_addr[dcount] <= prt_addr[p*AW +: AW];
            dlog_data[dcount] <= prt_wdata[p*DW +: DW];
            dlog_we[dcount]   <= prt_we[p];
            dlog_cyc[dcount]  <= cyc;
          end
          f = f + 1;
        end
        if (prt_rsp_valid[p] && prt_rsp_ready[p]) begin
          rp[p] <= rp[p] + 1'b1;
          g = g + 1;
        end
      end
      dcount <= dcount + f;
      ostd <= ostd + f - g;
      if (ostd > ostd_max) ostd_max <= ostd;
      if (rsp_valid && rcount < 64) begin
        rlog_port[rcount] <= rsp_port;
        rlog_data[rcount] <= rsp_data;
        rcount <= rcount + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk(input int i, input int p);
    return 32'h0000_4000 + 32'(i * 16) + 32'(p);
  endfunction

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic push(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    req_valid = 1'b1;
    req_addr  = a;
    req_we    = w;
    req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic stop_in;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(prt_valid == '0, "R9", "prt_valid after reset", 64'(prt_valid), 0);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 64'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R9", "req_ready after reset", 64'(req_ready), 1);
    @(posedge clk);
    #1;
  endtask

  task automatic t_stream;
    int d0, r0, p;
    d0 = dcount;
    r0 = rcount;
    for (int i = 0; i < 8; i++) begin
      p = (exp_ptr + i) % N;
      push(mk(i, p), 1'(i), 32'hA500_0000 + 32'(i));
    end
    stop_in();
    wait_cycles(10);
    chk(dcount - d0 == 8, "R1", "stream delivery count", 64'(dcount - d0), 8);
    for (int k = 0; k < 8; k++) begin
      p = (exp_ptr + k) % N;
      chk(dlog_port[d0+k] == IW'(p), (k == 0) ? "R9" : "R2", "rotation target",
          64'(dlog_port[d0+k]), 64'(p));
      chk(dlog_addr[d0+k] == mk(k, p) && dlog_we[d0+k] == 1'(k) &&
          dlog_data[d0+k] == 32'hA500_0000 + 32'(k), "R1", "payload addr",
          64'(dlog_addr[d0+k]), 64'(mk(k, p)));
      if (k > 0)
        chk(dlog_cyc[d0+k] - dlog_cyc[d0+k-1] == 1, "R4", "back-to-back spacing",
            64'(dlog_cyc[d0+k] - dlog_cyc[d0+k-1]), 1);
    end
    exp_ptr = (exp_ptr + 8) % N;
    chk(rcount - r0 == 8, "R7", "merged response count", 64'(rcount - r0), 8);
    for (int k = r0; k < rcount; k++)
      chk(rlog_data[k][1:0] == rlog_port[k] && rlog_data[k][31:28] == 4'h1, "R7",
          "response tag", 64'(rlog_port[k]), 64'(rlog_data[k][1:0]));
  endtask

  task automatic t_serial;
    int d0, p;
    cfg_serial = 1'b1;
    wait_cycles(2);
    ostd_max = 0;
    d0 = dcount;
    for (int i = 0; i < 4; i++) begin
      p = (exp_ptr + i) % N;
      push(mk(i, p), 1'b0, 32'h0);
    end
    stop_in();
    wait_cycles(8);
    chk(ostd_max <= 1, "R5", "max outstanding in serial", 64'(ostd_max), 1);
    for (int k = 0; k < 4; k++) begin
      p = (exp_ptr + k) % N;
      chk(dlog_port[d0+k] == IW'(p), "R2", "serial rotation", 64'(dlog_port[d0+k]), 64'(p));
      if (k > 0)
        chk(dlog_cyc[d0+k] - dlog_cyc[d0+k-1] == 3, "R5", "serial spacing",
            64'(dlog_cyc[d0+k] - dlog_cyc[d0+k-1]), 3);
    end
    exp_ptr = (exp_ptr + 4) % N;
  endtask

  task automatic t_defer;
    int d0, p;
    rsp_hold = 1'b1;
    d0 = dcount;
    p = exp_ptr;
    push(mk(0, p), 1'b1, 32'h1111);
    exp_ptr = (exp_ptr + 1) % N;
    wait_cycles(2);
    cfg_serial = 1'b0;
    req_valid = 1'b1;
    req_addr = mk(1, exp_ptr);
    req_we = 1'b0;
    req_wdata = 32'h2222;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R8", "input held while serial wait", 64'(req_ready), 0);
    end
    chk(dcount - d0 == 1, "R5", "no second delivery while waiting", 64'(dcount - d0), 1);
    @(posedge clk);
    #1;
    rsp_hold = 1'b0;
    push(mk(1, exp_ptr), 1'b0, 32'h2222);
    stop_in();
    wait_cycles(6);
    chk(dlog_port[d0+1] == IW'(exp_ptr), "R2", "target after deferred switch",
        64'(dlog_port[d0+1]), 64'(exp_ptr));
    exp_ptr = (exp_ptr + 1) % N;
    d0 = dcount;
    push(mk(2, exp_ptr), 1'b0, 32'h0);
    push(mk(3, (exp_ptr + 1) % N), 1'b0, 32'h0);
    stop_in();
    exp_ptr = (exp_ptr + 2) % N;
    wait_cycles(6);
    chk(dlog_cyc[d0+1] - dlog_cyc[d0] == 1, "R8", "streaming active after idle gap",
        64'(dlog_cyc[d0+1] - dlog_cyc[d0]), 1);
  endtask

  task automatic t_single;
    int d0;
    cfg_single = 1'b1;
    cfg_port = 2'd2;
    wait_cycles(2);
    d0 = dcount;
    for (int i = 0; i < 4; i++) push(mk(i, 2), 1'b1, 32'(i));
    stop_in();
    wait_cycles(6);
    for (int k = 0; k < 4; k++)
      chk(dlog_port[d0+k] == 2'd2, "R3", "pinned target", 64'(dlog_port[d0+k]), 2);
    cfg_single = 1'b0;
    wait_cycles(2);
    d0 = dcount;
    push(mk(9, exp_ptr), 1'b0, 32'h0);
    stop_in();
    wait_cycles(4);
    chk(dlog_port[d0] == IW'(exp_ptr), "R3", "rotation resumes where frozen",
        64'(dlog_port[d0]), 64'(exp_ptr));
    exp_ptr = (exp_ptr + 1) % N;
  endtask

  task automatic t_backpressure;
    int d0, p, p1;
    p = exp_ptr;
    p1 = (exp_ptr + 1) % N;
    rdy_en[p] = 1'b0;
    d0 = dcount;
    push(mk(5, p), 1'b0, 32'h5);
    req_valid = 1'b1;
    req_addr = mk(6, p1);
    req_we = 1'b0;
    req_wdata = 32'h6;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R6", "input blocked behind held request", 64'(req_ready), 0);
      chk(prt_valid == (N'(1) << p), "R6", "held port valid", 64'(prt_valid), 64'(N'(1) << p));
      chk(prt_addr[p*AW +: AW] == mk(5, p), "R6", "held address",
          64'(prt_addr[p*AW +: AW]), 64'(mk(5, p)));
    end
    chk(dcount == d0, "R6", "nothing delivered while blocked", 64'(dcount - d0), 0);
    @(posedge clk);
    #1;
    rdy_en[p] = 1'b1;
    push(mk(6, p1), 1'b0, 32'h6);
    stop_in();
    wait_cycles(4);
    chk(dlog_port[d0] == IW'(p) && dlog_addr[d0] == mk(5, p), "R6", "first after release",
        64'(dlog_addr[d0]), 64'(mk(5, p)));
    chk(dlog_port[d0+1] == IW'(p1) && dlog_addr[d0+1] == mk(6, p1), "R6", "second in order",
        64'(dlog_addr[d0+1]), 64'(mk(6, p1)));
    exp_ptr = (exp_ptr + 2) % N;
  endtask

  task automatic t_merge;
    int p, p1, lo, hi;
    p = exp_ptr;
    p1 = (exp_ptr + 1) % N;
    lo = (p < p1) ? p : p1;
    hi = (p < p1) ? p1 : p;
    rsp_hold = 1'b1;
    push(mk(7, p), 1'b0, 32'h0);
    push(mk(8, p1), 1'b0, 32'h0);
    stop_in();
    exp_ptr = (exp_ptr + 2) % N;
    wait_cycles(4);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "no response while held", 64'(rsp_valid), 0);
    @(posedge clk);
    #1;
    rsp_hold = 1'b0;
    @(negedge clk);
    chk(prt_rsp_ready == (N'(1) << lo), "R7", "grant to lowest index",
        64'(prt_rsp_ready), 64'(N'(1) << lo));
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_port == IW'(lo), "R7", "first merged port",
        64'(rsp_port), 64'(lo));
    chk(rsp_data == mk(lo == p ? 7 : 8, lo) + 32'h1000_0000, "R7", "first merged data",
        64'(rsp_data), 64'(mk(lo == p ? 7 : 8, lo) + 32'h1000_0000));
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_port == IW'(hi), "R7", "second merged port",
        64'(rsp_port), 64'(hi));
    wait_cycles(3);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cfg_serial = 1'b0;
    cfg_single = 1'b0;
    cfg_port = '0;
    req_valid = 1'b0;
    req_we = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    rdy_en = '1;
    rsp_hold = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_stream();
    t_serial();
    t_defer();
    t_single();
    t_backpressure();
    t_merge();
    done = 1;
    summary();
    $finish;
  end

endmodule